// File: doc/BRIEF.md
# Register-Bus Command Bridge

This block lets a processor reach the 8-bit control registers of a hard SPI controller through a single memory-mapped 32-bit word. One full-word store packs three things: the target register number, the byte to write and a direction bit. That store starts exactly one transaction on a small strobe/acknowledge register bus.

Software polls a busy flag in the top byte of the same word. It waits for the flag to clear before it issues a command, and waits again before it collects a read result. The byte returned by the controller is kept in a received-byte field. That field shares byte 2 with the direction bit: byte 2 is the direction when written and the received data when read.

The bus master holds strobe and the command steady until the controller acknowledges, however long that takes. Because the latency is variable, software never needs to know the controller's timing.

Top module: `regbus_bridge`

## Requirements
- R1: After a synchronous active-high reset the bridge is idle: strobe low, busy flag 0 and received byte 0x00.
- R2: A store with all four byte enables set to the word at `BASE_ADDR` (default 0x00000008), made while idle, raises strobe and busy on the next clock. The bus then carries register address = write data bits [15:8], bus data = bits [7:0] and write-enable = bit 16 (1 = write, 0 = read). For example, 0x00010980 writes 0x80 to register 0x09 and 0x00000C00 reads register 0x0C.
- R3: While strobe is high and acknowledge is low, strobe stays high and the bus address, bus data and write-enable do not change.
- R4: In the cycle after acknowledge is sampled with strobe high, strobe is low and the busy flag reads 0.
- R5: On a read transaction, the bus read data present with the acknowledge becomes the received byte, visible in read-data bits [23:16].
- R6: A write transaction leaves the received byte unchanged.
- R7: A store to the bridge word while busy is ignored: busy stays 1 and the bus address, data and direction of the running transaction do not change.
- R8: A store with any byte enable clear, or a store to any other address, starts nothing and the bridge stays idle.
- R9: Reading the bridge word returns the last command data in bits [7:0], the last command address in [15:8], the received byte in [23:16] and busy in bit 24, with bits [31:25] zero. A read at any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wr | input | 1 | Processor store request this cycle |
| cpu_wstrb | input | 4 | Byte enables of the store |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Combinational read data for `cpu_addr` |
| sb_stb | output | 1 | Register-bus strobe |
| sb_we | output | 1 | Register-bus write enable (1 = write) |
| sb_addr | output | 8 | Register-bus register address |
| sb_wdata | output | 8 | Register-bus write data |
| sb_rdata | input | 8 | Register-bus read data, valid with acknowledge |
| sb_ack | input | 1 | Register-bus acknowledge, one cycle |

## Verification
The assertions assume the controller raises acknowledge only while strobe is high and holds it for exactly one cycle. They also assume read data is valid in the same cycle as the acknowledge. The bench's controller model acknowledges after a programmable wait of zero to several cycles, drops acknowledge on the following cycle, and never acknowledges an idle bus. Processor stores are driven between clock edges, so busy-time stores, partial stores and misaddressed stores all reach the bridge while the bus behaves legally.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_WAIT = 1'b1
    } xfer_state_t;

    typedef struct packed {
        logic              we;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } regbus_cmd_t;

    function automatic regbus_cmd_t cmd_from_word(input logic [31:0] w);
        regbus_cmd_t c;
        c.data = w[7:0];
        c.addr = w[15:8];
        c.we   = w[16];
        return c;
    endfunction

    function automatic logic [31:0] word_from_state(input regbus_cmd_t c,
                                                    input logic [BYTE_W-1:0] rx,
                                                    input logic busy);
        return {7'b0, busy, rx, c.addr, c.data};
    endfunction

endpackage

// File: rtl/regbus_cmd_reg.sv
module regbus_cmd_reg
    import regbus_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          WORD_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0000_0008
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_wr,
    input  logic [WORD_W/8-1:0] cpu_wstrb,
    input  logic [WORD_W-1:0]   cpu_wdata,
    output logic [WORD_W-1:0]   cpu_rdata,
    input  logic                busy,
    input  logic [BYTE_W-1:0]   rx_byte,
    output logic                start,
    output regbus_cmd_t         cmd
);
    localparam int STRB_W = WORD_W / 8;

    logic hit;
    logic full_word;
    logic [WORD_W-1:0] unused_wdata;

    assign hit          = (cpu_addr == BASE_ADDR[ADDR_W-1:0]);
    assign full_word    = (cpu_wstrb == {STRB_W{1'b1}});
    assign start        = cpu_wr && hit && full_word && !busy;
    assign unused_wdata = cpu_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else if (start) begin
            cmd <= cmd_from_word(cpu_wdata[31:0]);
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (hit) begin
            cpu_rdata[31:0] = word_from_state(cmd, rx_byte, busy);
        end
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    assert_partial_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !busy && !(hit && full_word)) |=> !busy);

endmodule

// File: rtl/regbus_master.sv
module regbus_master
    import regbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  regbus_cmd_t       cmd,
    output logic              sb_stb,
    output logic              sb_we,
    output logic [BYTE_W-1:0] sb_addr,
    output logic [BYTE_W-1:0] sb_wdata,
    input  logic [BYTE_W-1:0] sb_rdata,
    input  logic              sb_ack,
    output logic              busy,
    output logic [BYTE_W-1:0] rx_byte
);
    xfer_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= XF_IDLE;
            rx_byte <= '0;
        end else begin
            unique case (state)
                XF_IDLE: if (start) state <= XF_WAIT;
                XF_WAIT: begin
                    if (sb_ack) begin
                        state <= XF_IDLE;
                        if (!cmd.we) rx_byte <= sb_rdata;
                    end
                end
                default: state <= XF_IDLE;
            endcase
        end
    end

    assign busy     = (state == XF_WAIT);
    assign sb_stb   = busy;
    assign sb_we    = cmd.we;
    assign sb_addr  = cmd.addr;
    assign sb_wdata = cmd.data;

    assert_stb_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (sb_stb && !sb_ack) |=> (sb_stb && $stable(sb_addr) && $stable(sb_wdata) && $stable(sb_we)));

    assert_drop_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
        (sb_stb && sb_ack) |=> !sb_stb);

    assert_read_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (sb_stb && sb_ack && !sb_we) |=> (rx_byte == $past(sb_rdata)));

    assert_write_keeps_rx_R6: assert property (@(posedge clk) disable iff (rst)
        (sb_stb && sb_ack && sb_we) |=> $stable(rx_byte));

    assert_idle_rx_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !sb_stb |=> $stable(rx_byte));

endmodule

// File: rtl/regbus_bridge.sv
module regbus_bridge
    import regbus_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          WORD_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0000_0008
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_wr,
    input  logic [WORD_W/8-1:0] cpu_wstrb,
    input  logic [WORD_W-1:0]   cpu_wdata,
    output logic [WORD_W-1:0]   cpu_rdata,
    output logic                sb_stb,
    output logic                sb_we,
    output logic [7:0]          sb_addr,
    output logic [7:0]          sb_wdata,
    input  logic [7:0]          sb_rdata,
    input  logic                sb_ack
);
    logic              start;
    logic              busy;
    logic [BYTE_W-1:0] rx_byte;
    regbus_cmd_t       cmd;

    regbus_cmd_reg #(
        .ADDR_W   (ADDR_W),
        .WORD_W   (WORD_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .cpu_wstrb(cpu_wstrb),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .busy     (busy),
        .rx_byte  (rx_byte),
        .start    (start),
        .cmd      (cmd)
    );

    regbus_master u_mst (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cmd     (cmd),
        .sb_stb  (sb_stb),
        .sb_we   (sb_we),
        .sb_addr (sb_addr),
        .sb_wdata(sb_wdata),
        .sb_rdata(sb_rdata),
        .sb_ack  (sb_ack),
        .busy    (busy),
        .rx_byte (rx_byte)
    );

    assert_busy_store_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (sb_stb && !sb_ack && cpu_wr) |=> (sb_stb && $stable(sb_addr) && $stable(sb_we)));

endmodule

// File: tb/regbus_bridge_tb.sv
`timescale 1ns/1ps
module regbus_bridge_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [3:0]  cpu_wstrb = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        sb_stb, sb_we, sb_ack;
    logic [7:0]  sb_addr, sb_wdata, sb_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  regfile [16];
    int          lat = 1;
    int          wcnt = 0;
    logic [16:0] expq [$];

    always #5 clk = ~clk;

    regbus_bridge u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wstrb(cpu_wstrb), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .sb_stb(sb_stb), .sb_we(sb_we), .sb_addr(sb_addr), .sb_wdata(sb_wdata),
        .sb_rdata(sb_rdata), .sb_ack(sb_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // controller model: acknowledge after lat wait cycles, one cycle wide
    initial begin
        sb_ack = 1'b0;
        sb_rdata = '0;
        forever begin
            @(negedge clk);
            if (sb_ack) begin
                sb_ack = 1'b0;
                wcnt = 0;
            end else if (sb_stb) begin
                if (wcnt >= lat) begin
                    sb_ack = 1'b1;
                    sb_rdata = regfile[sb_addr[3:0]];
                    if (sb_we) regfile[sb_addr[3:0]] = sb_wdata;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // monitor: compare each handshake with the scoreboard, then R4
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && sb_stb && sb_ack) begin
                logic [16:0] e;
                if (expq.size() == 0) begin
                    chk(1'b0, "R2 unexpected transaction", {15'b0, sb_we, sb_addr, sb_wdata}, 32'h0);
                end else begin
                    e = expq.pop_front();
                    chk(sb_we == e[16] && sb_addr == e[15:8] && (!e[16] || sb_wdata == e[7:0]),
                        "R3 bus command at ack", {15'b0, sb_we, sb_addr, sb_wdata}, {15'b0, e});
                end
                @(negedge clk);
                chk(!sb_stb, "R4 strobe low after ack", {31'b0, sb_stb}, 32'h0);
                cpu_addr = 32'h8;
                #1;
                chk(cpu_rdata[24] == 1'b0, "R4 busy clear after ack", cpu_rdata, 32'h0);
            end
        end
    end

    task automatic store(input logic [31:0] a, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wstrb = s; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        #2;
    endtask

    task automatic issue(input logic [31:0] d);
        expq.push_back(d[16:0]);
        store(32'h8, 4'hF, d);
    endtask

    task automatic wait_idle();
        int n = 0;
        cpu_addr = 32'h8;
        #1;
        while (cpu_rdata[24] && n < 100) begin
            @(negedge clk);
            cpu_addr = 32'h8;
            #1;
            n++;
        end
        @(negedge clk);
        #2;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] v);
        cpu_addr = a;
        #1;
        v = cpu_rdata;
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 16; i++) regfile[i] = 8'(i * 17 + 3);
        regfile[12] = 8'h5A;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        rd(32'h8, v);
        chk(v == 32'h0, "R1 reset readback", v, 32'h0);
        chk(!sb_stb, "R1 strobe low after reset", {31'b0, sb_stb}, 32'h0);

        lat = 4;
        issue(32'h0001_0980);
        chk(sb_stb && sb_we && sb_addr == 8'h09 && sb_wdata == 8'h80, "R2 write command on bus",
            {15'b0, sb_we, sb_addr, sb_wdata}, 32'h0001_0980);
        rd(32'h8, v);
        chk(v[24], "R2 busy set", v, 32'h0100_0000);
        store(32'h8, 4'hF, 32'h0000_0C00);
        chk(sb_stb && sb_addr == 8'h09 && sb_we, "R7 busy store ignored", {15'b0, sb_we, sb_addr, sb_wdata}, 32'h0001_0980);
        chk(sb_wdata == 8'h80, "R3 data held while waiting", {24'b0, sb_wdata}, 32'h80);
        wait_idle();
        rd(32'h8, v);
        chk(v == 32'h0000_0980, "R9 readback after write", v, 32'h0000_0980);

        lat = 2;
        issue(32'h0000_0C00);
        wait_idle();
        rd(32'h8, v);
        chk(v == 32'h005A_0C00, "R5 read captures byte", v, 32'h005A_0C00);

        lat = 0;
        issue(32'h0001_0C33);
        wait_idle();
        rd(32'h8, v);
        chk(v[23:16] == 8'h5A, "R6 write keeps received byte", v, 32'h005A_0C33);
        chk(regfile[12] == 8'h33, "R2 write reached register", {24'b0, regfile[12]}, 32'h33);

        issue(32'h0000_0C00);
        wait_idle();
        rd(32'h8, v);
        chk(v[23:16] == 8'h33, "R5 read after zero latency", v, 32'h0033_0C00);

        lat = 3;
        issue(32'h0000_0900);
        wait_idle();
        rd(32'h8, v);
        chk(v == 32'h0080_0900, "R5 read of register 9", v, 32'h0080_0900);

        store(32'h8, 4'h3, 32'h0001_0411);
        chk(!sb_stb, "R8 partial store ignored", {31'b0, sb_stb}, 32'h0);
        rd(32'h8, v);
        chk(v == 32'h0080_0900, "R8 partial store leaves word", v, 32'h0080_0900);
        store(32'hC, 4'hF, 32'h0001_0411);
        chk(!sb_stb, "R8 other address ignored", {31'b0, sb_stb}, 32'h0);
        rd(32'h4, v);
        chk(v == 32'h0, "R9 other address reads zero", v, 32'h0);

        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R2 all transactions seen", expq.size(), 32'h0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule